// File: doc/BRIEF.md
# Host Bus Interface with Parallel and Serial Modes

This block sits between a host processor and the command and display-data logic of a display controller. It accepts transfers over an 8-bit parallel bus or over a write-only serial link. Each accepted transfer comes out as a one-cycle strobe in the system clock domain. The strobe carries a data/command flag and one data byte. In parallel mode the block also returns read data: it raises a read request, forwards the read-data byte from the core onto its data output, and asserts an output enable for as long as the host read lasts.

Two straps choose the bus. With the parallel strap high, a style strap chooses between two protocols. In the strobe style, separate read and write lines are both active low. In the enable style, an active-high enable works together with a read/write line. With the parallel strap low, a second strap chooses the serial variant. The 4-wire variant uses a dedicated data/command pin. The 3-wire variant has no such pin, so it carries the flag as an extra final bit of a 17-bit frame. Every bus pin passes through a two-flop synchroniser, and all strobe and clock edges are detected in the system clock domain.

Top module: `host_bus_if`

## Requirements
- R1: While reset is held and after it is released, with the bus idle (chip select high), xfer_valid_o, rd_req_o and data_oe_o are all low.
- R2: Strobe style (par_sel_i=1, style68_i=0): a rising edge of wr_i while cs_n_i is low produces exactly one xfer_valid_o pulse. The pulse carries the data_i byte and xfer_dc_o equal to dc_i (1 = display data, 0 = instruction). It is visible in the third clock cycle after the edge.
- R3: Enable style (par_sel_i=1, style68_i=1, enable on rd_i, read/write on wr_i): a falling edge of the enable while wr_i is low (write) and cs_n_i is low produces one strobe, with the same fields and latency as in R2.
- R4: Strobe-style read: while cs_n_i and rd_i are both low, data_oe_o is high and data_o carries rd_data_i. Three cycles after the start, rd_req_o pulses for one cycle with rd_dc_o equal to dc_i.
- R5: Enable-style read: while cs_n_i is low, the enable is high and wr_i is high (read), data_oe_o is high and data_o carries rd_data_i. rd_req_o pulses once at the start.
- R6: While cs_n_i is high, write edges produce no strobe, and read levels produce neither a data_oe_o nor a rd_req_o.
- R7: 4-wire serial (par_sel_i=0, ser3_sel_i=0): the bit on data_i[7] is shifted in MSB first on each rising edge of data_i[6]. The eighth bit completes a byte, and dc_i is sampled at that eighth edge. The strobe appears three cycles after the edge.
- R8: 3-wire serial (ser3_sel_i=1): a frame is 17 bits. Bits 1 to 8 form the first byte and bits 9 to 16 the second byte, each MSB first, and bit 17 is the data/command flag. The frame yields two strobes in consecutive cycles, first byte first, both carrying the flag. The first strobe appears three cycles after the 17th edge.
- R9: Raising cs_n_i in the middle of a serial frame discards the partial bits. The next frame starts again from bit 1.
- R10: Serial mode is write-only. data_oe_o and rd_req_o stay low, and rd_i/wr_i activity produces no strobe.
- R11: In parallel mode, toggling data_i[6] and data_i[7] without a write edge produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_sel_i | input | 1 | Strap: 1 parallel, 0 serial |
| ser3_sel_i | input | 1 | Strap: 1 selects the 3-wire serial variant, 0 the 4-wire variant |
| style68_i | input | 1 | Strap: 1 enable style, 0 strobe style |
| cs_n_i | input | 1 | Chip select, active low |
| dc_i | input | 1 | Data/command: 1 display data, 0 instruction |
| rd_i | input | 1 | Read strobe (active low) or enable (active high) |
| wr_i | input | 1 | Write strobe (active low) or read/write line (1 read) |
| data_i | input | DW | Parallel data in; bit 7 is serial data and bit 6 is the serial clock |
| rd_data_i | input | DW | Read-data byte supplied by the core |
| data_o | output | DW | Read data toward the host pins |
| data_oe_o | output | 1 | Output enable for data_o |
| rd_req_o | output | 1 | One-cycle pulse at the start of a host read |
| rd_dc_o | output | 1 | Data/command flag of that read |
| xfer_valid_o | output | 1 | One-cycle strobe for an accepted write |
| xfer_dc_o | output | 1 | Data/command flag of the strobe |
| xfer_data_o | output | DW | Byte of the strobe |

## Verification
On every cycle, the assertions check the following. Each write path emits single-cycle pulses. A high chip select blocks strobes and read requests on the next cycle. The serial bit counter stays within its frame length and returns to zero once chip select is high. Serial mode never drives the data bus. The bench scenarios are needed for the rest: the exact three-cycle latency, the byte values and MSB-first order, sampling of the data/command flag on the eighth edge, the two-byte split of a 3-wire frame, and the discard of a partial frame. The bench checks these by comparing every strobe, with its cycle number, against a queue of predicted events.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned SDI_BIT   = 7;
  localparam int unsigned SCLK_BIT  = 6;

  // bits per serial frame for the selected variant
  function automatic int unsigned frame_bits(input logic three_wire, input int unsigned w);
    return three_wire ? (2 * w + 1) : w;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbi_par.sv
module hbi_par #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          style68,
  input  logic          cs_n,
  input  logic          dc,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] rd_data,
  output logic          ev_valid,
  output logic          ev_dc,
  output logic [DW-1:0] ev_data,
  output logic          rd_req,
  output logic          rd_dc,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic rd_p, wr_p, phase_p;

  // named events for checking
  wire sel      = en & ~cs_n;
  wire wr_edge  = sel & (style68 ? (rd_p & ~rd & ~wr) : (~wr_p & wr));
  wire rd_phase = sel & (style68 ? (rd & wr) : ~rd);
  wire rd_start = rd_phase & ~phase_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p     <= 1'b1;
      wr_p     <= 1'b1;
      phase_p  <= 1'b0;
      ev_valid <= 1'b0;
      ev_dc    <= 1'b0;
      ev_data  <= '0;
      rd_req   <= 1'b0;
      rd_dc    <= 1'b0;
      oe       <= 1'b0;
      dout     <= '0;
    end else begin
      rd_p     <= rd;
      wr_p     <= wr;
      phase_p  <= rd_phase;
      ev_valid <= wr_edge;
      if (wr_edge) begin
        ev_dc   <= dc;
        ev_data <= data;
      end
      rd_req <= rd_start;
      if (rd_start) rd_dc <= dc;
      oe   <= rd_phase;
      dout <= rd_phase ? rd_data : '0;
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);
  p_cs_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!ev_valid && !rd_req && !oe));
  p_req_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_req_with_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> oe);
endmodule

// File: rtl/hbi_ser.sv
module hbi_ser
  import hbi_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          three_wire,
  input  logic          cs_n,
  input  logic          dc,
  input  logic          sclk,
  input  logic          sdi,
  output logic          ev_valid,
  output logic          ev_dc,
  output logic [DW-1:0] ev_data
);
  localparam int unsigned FRAME3 = 2 * DW + 1;
  localparam int unsigned CW     = $clog2(FRAME3);

  logic [CW-1:0]   cnt;
  logic [2*DW-1:0] shreg;
  logic            sclk_p;
  logic            pend_v;
  logic [DW-1:0]   pend_data;

  wire sclk_rise  = en & ~cs_n & sclk & ~sclk_p;
  wire last_bit   = (cnt == CW'(frame_bits(three_wire, DW) - 1));
  wire frame_done = sclk_rise & last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      sclk_p    <= 1'b0;
      pend_v    <= 1'b0;
      pend_data <= '0;
      ev_valid  <= 1'b0;
      ev_dc     <= 1'b0;
      ev_data   <= '0;
    end else begin
      sclk_p   <= sclk;
      ev_valid <= 1'b0;
      if (pend_v) begin
        ev_valid <= 1'b1;
        ev_data  <= pend_data;
        pend_v   <= 1'b0;
      end
      if (cs_n || !en) begin
        cnt <= '0;
      end else if (frame_done) begin
        cnt      <= '0;
        ev_valid <= 1'b1;
        if (three_wire) begin
          ev_dc     <= sdi;
          ev_data   <= shreg[2*DW-1:DW];
          pend_v    <= 1'b1;
          pend_data <= shreg[DW-1:0];
        end else begin
          ev_dc   <= dc;
          ev_data <= {shreg[DW-2:0], sdi};
        end
      end else if (sclk_rise) begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[2*DW-2:0], sdi};
      end
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME3 - 1));
  p_cs_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt == '0));
  p_byte_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!three_wire && ev_valid) |=> !ev_valid);
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import hbi_pkg::*;
#(
  parameter int unsigned DW = hbi_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_sel_i,
  input  logic          ser3_sel_i,
  input  logic          style68_i,
  input  logic          cs_n_i,
  input  logic          dc_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rd_req_o,
  output logic          rd_dc_o,
  output logic          xfer_valid_o,
  output logic          xfer_dc_o,
  output logic [DW-1:0] xfer_data_o
);
  localparam int unsigned SW = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {4'b1011, {DW{1'b0}}};

  logic [SW-1:0] bus_q;
  logic          cs_q, dc_q, rd_q, wr_q;
  logic [DW-1:0] dat_q;

  hbi_sync #(.W(SW), .RST(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n_i, dc_i, rd_i, wr_i, data_i}),
    .q(bus_q)
  );
  assign {cs_q, dc_q, rd_q, wr_q, dat_q} = bus_q;

  logic          p_valid, p_dc, s_valid, s_dc;
  logic [DW-1:0] p_data, s_data;

  hbi_par #(.DW(DW)) u_par (
    .clk(clk), .rst_n(rst_n), .en(par_sel_i), .style68(style68_i),
    .cs_n(cs_q), .dc(dc_q), .rd(rd_q), .wr(wr_q), .data(dat_q),
    .rd_data(rd_data_i),
    .ev_valid(p_valid), .ev_dc(p_dc), .ev_data(p_data),
    .rd_req(rd_req_o), .rd_dc(rd_dc_o), .oe(data_oe_o), .dout(data_o)
  );

  hbi_ser #(.DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(~par_sel_i), .three_wire(ser3_sel_i),
    .cs_n(cs_q), .dc(dc_q), .sclk(dat_q[SCLK_BIT]), .sdi(dat_q[SDI_BIT]),
    .ev_valid(s_valid), .ev_dc(s_dc), .ev_data(s_data)
  );

  assign xfer_valid_o = par_sel_i ? p_valid : s_valid;
  assign xfer_dc_o    = par_sel_i ? p_dc    : s_dc;
  assign xfer_data_o  = par_sel_i ? p_data  : s_data;

  p_serial_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !par_sel_i |-> (!data_oe_o && !rd_req_o));
  p_oe_needs_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> !$past(cs_q));
endmodule

// File: tb/host_bus_if_test.sv
module host_bus_if_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       par_sel = 1'b1, ser3 = 1'b0, st68 = 1'b0;
  logic       cs_n = 1'b1, dc = 1'b0, rd = 1'b1, wr = 1'b1;
  logic [7:0] din = 8'h00, rdd = 8'h00;
  logic [7:0] dout, xdata;
  logic       oe, rreq, rdc, xv, xdc;

  int checks = 0, fails = 0, cyc = 0, lastc = 0;
  int         qcyc[$];
  logic [8:0] qev[$];

  always #4 clk = ~clk;

  host_bus_if uut (
    .clk(clk), .rst_n(rst_n), .par_sel_i(par_sel), .ser3_sel_i(ser3),
    .style68_i(st68), .cs_n_i(cs_n), .dc_i(dc), .rd_i(rd), .wr_i(wr),
    .data_i(din), .rd_data_i(rdd), .data_o(dout), .data_oe_o(oe),
    .rd_req_o(rreq), .rd_dc_o(rdc), .xfer_valid_o(xv), .xfer_dc_o(xdc),
    .xfer_data_o(xdata)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // reference log of every strobe with its cycle
  always @(posedge clk) begin
    #1;
    if (rst_n && xv) begin
      qcyc.push_back(cyc);
      qev.push_back({xdc, xdata});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_ev(input string tag, input logic edc, input logic [7:0] ed, input int ec);
    checks++;
    if (qev.size() == 0) begin
      fails++;
      $display("FAIL %s actual=none expected=%0h@%0d", tag, {edc, ed}, ec);
    end else begin
      logic [8:0] a;
      int ac;
      a  = qev.pop_front();
      ac = qcyc.pop_front();
      if (a !== {edc, ed} || ac != ec) begin
        fails++;
        $display("FAIL %s actual=%0h@%0d expected=%0h@%0d", tag, a, ac, {edc, ed}, ec);
      end
    end
  endtask

  task automatic exp_none(input string tag);
    checks++;
    if (qev.size() != 0) begin
      fails++;
      $display("FAIL %s actual=%0d strobes expected=0", tag, qev.size());
      qev.delete();
      qcyc.delete();
    end
  endtask

  task automatic wr80(input logic d_c, input logic [7:0] v, input string tag);
    int c;
    cs_n = 0; dc = d_c; din = v; wr = 0;
    tick(4);
    wr = 1; c = cyc;
    tick(5);
    cs_n = 1;
    tick(2);
    exp_ev(tag, d_c, v, c + 3);
    exp_none(tag);
  endtask

  task automatic wr68(input logic d_c, input logic [7:0] v, input string tag);
    int c;
    cs_n = 0; dc = d_c; din = v; wr = 0; rd = 1;
    tick(4);
    rd = 0; c = cyc;
    tick(5);
    wr = 1; cs_n = 1;
    tick(2);
    exp_ev(tag, d_c, v, c + 3);
    exp_none(tag);
  endtask

  task automatic sbit(input logic b);
    din[7] = b; din[6] = 0;
    tick(3);
    din[6] = 1; lastc = cyc;
    tick(3);
  endtask

  task automatic sbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
  endtask

  initial begin
    // R1 reset state
    tick(3);
    chk(!xv && !oe && !rreq, "R1 during reset", {xv, oe, rreq}, 0);
    rst_n = 1;
    tick(6);
    chk(!xv && !oe && !rreq, "R1 after reset", {xv, oe, rreq}, 0);
    exp_none("R1 no strobe");

    // R2 strobe-style writes
    wr80(1'b1, 8'hA5, "R2 data write");
    wr80(1'b0, 8'h3C, "R2 command write");
    wr80(1'b1, 8'hFF, "R2 all ones");

    // R11 serial pins toggled in parallel mode
    cs_n = 0;
    for (int i = 0; i < 6; i++) begin din[6] = ~din[6]; din[7] = din[6]; tick(4); end
    cs_n = 1; din = 0;
    tick(4);
    exp_none("R11 no strobe from serial pins");

    // R4 strobe-style read
    rdd = 8'h5A; dc = 1; cs_n = 0; rd = 0;
    tick(3);
    chk(oe && dout == 8'h5A, "R4 read drive", {oe, dout}, {1'b1, 8'h5A});
    chk(rreq && rdc, "R4 read request", {rreq, rdc}, 2'b11);
    tick(1);
    chk(!rreq && oe, "R4 request single", {rreq, oe}, 2'b01);
    rd = 1;
    tick(3);
    chk(!oe && !rreq, "R4 release", {oe, rreq}, 0);
    cs_n = 1;

    // R6 chip select high blocks everything
    din = 8'h77; wr = 0; tick(4); wr = 1; tick(2); rd = 0;
    tick(6);
    chk(!oe && !rreq, "R6 read blocked", {oe, rreq}, 0);
    rd = 1; tick(3);
    exp_none("R6 write blocked");

    // R3 enable-style writes
    st68 = 1; rd = 0; wr = 1;
    tick(4);
    wr68(1'b1, 8'hC3, "R3 data write");
    wr68(1'b0, 8'h01, "R3 command write");

    // R5 enable-style read
    rdd = 8'h96; dc = 0; cs_n = 0; wr = 1; rd = 1;
    tick(3);
    chk(oe && dout == 8'h96, "R5 read drive", {oe, dout}, {1'b1, 8'h96});
    chk(rreq && !rdc, "R5 read request", {rreq, rdc}, 2'b10);
    rd = 0;
    tick(3);
    chk(!oe, "R5 release", oe, 0);
    cs_n = 1;
    tick(4);
    exp_none("R5 read gives no strobe");

    // R7 4-wire serial, dc sampled on eighth bit
    cs_n = 1; din = 0; st68 = 0; rd = 1; wr = 1; par_sel = 0; ser3 = 0;
    tick(4);
    cs_n = 0; dc = 0;
    for (int i = 7; i >= 1; i--) sbit(1'(8'hB2 >> i));
    dc = 1;
    sbit(1'b0);
    dc = 0;
    tick(2);
    exp_ev("R7 byte with late dc", 1'b1, 8'hB2, lastc + 3);
    sbyte(8'h4D);
    tick(2);
    exp_ev("R7 second byte", 1'b0, 8'h4D, lastc + 3);
    cs_n = 1;

    // R9 partial frame discarded
    tick(4);
    cs_n = 0;
    for (int i = 0; i < 5; i++) sbit(1'b1);
    cs_n = 1; tick(5); cs_n = 0;
    sbyte(8'h18);
    tick(2);
    exp_ev("R9 restart after cs", 1'b0, 8'h18, lastc + 3);
    exp_none("R9 no extra");
    cs_n = 1;

    // R10 serial is write only
    cs_n = 0; din = 0; rdd = 8'hEE;
    rd = 0; tick(5); wr = 0; tick(4); wr = 1; tick(4);
    chk(!oe && !rreq, "R10 no drive in serial", {oe, rreq}, 0);
    rd = 1; tick(4);
    exp_none("R10 no strobe in serial");
    cs_n = 1;

    // R8 3-wire frame
    ser3 = 1; tick(4);
    cs_n = 0; dc = 0;
    sbyte(8'hE1); sbyte(8'h7E); sbit(1'b1);
    tick(3);
    exp_ev("R8 first byte", 1'b1, 8'hE1, lastc + 3);
    exp_ev("R8 second byte", 1'b1, 8'h7E, lastc + 4);
    sbyte(8'h00); sbyte(8'h99); sbit(1'b0);
    tick(3);
    exp_ev("R8 command first", 1'b0, 8'h00, lastc + 3);
    exp_ev("R8 command second", 1'b0, 8'h99, lastc + 4);
    exp_none("R8 no extra");
    cs_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule